// File: doc/BRIEF.md
# SMBus Byte-Access Register Target

This block is the serial front end of a small register bank. It watches an SMBus/I2C clock and data pair, recognises its own 7-bit target address, and gives a host byte-wide access to eight 8-bit registers through three transaction shapes. A write transaction carries a command byte and one data byte. A combined read carries a command byte, then a repeated START and a read-direction address, and returns one byte. A short read returns the register named by the most recently latched command, with no command phase. The register storage sits outside the block. The block issues a one-cycle write strobe with the data byte, exposes the latched command pointer, and takes the selected register's contents back on a read-data input.

The upper four address bits are fixed at binary 1000. The lower three bits come from strap pins that are sampled once, in the first clock after power-up reset. Eight targets can therefore share a bus. Bus lines pass through a two-stage synchroniser. Edge and START/STOP detection run on the synchronised copies, and the block pulls SDA low through a drive-low enable.

The controller is one state machine with these states: IDLE, ADDR, ADDR_ACK, CMD, CMD_ACK, WDATA, WDATA_ACK, RDATA, RDATA_ACK and IGNORE. A START from any state moves to ADDR. A STOP from any state moves to IDLE. After eight bits and the following SCL fall, the machine moves as follows:
- ADDR goes to ADDR_ACK on a match and to IGNORE on a mismatch.
- CMD goes to CMD_ACK.
- WDATA goes to WDATA_ACK.
- RDATA goes to RDATA_ACK.

At the SCL fall that closes the ninth clock, the machine moves as follows:
- ADDR_ACK goes to CMD for a write-direction address, or to RDATA for a read-direction address.
- CMD_ACK goes to WDATA.
- WDATA_ACK and RDATA_ACK both go to IGNORE.

Top module: `smb_regbank_target`

## Requirements
- R1: The target address is 7'b1000 concatenated with the strap bits {strap[2], strap[1], strap[0]}, with strap[0] as the LSB. An address byte is ACKed only on an exact match. On a mismatch SDA stays released and the rest of the transaction is ignored.
- R2: The straps are captured once, in the first clock after reset. Later strap changes do not alter the address.
- R3: A write transaction (address with R/W=0, command, data) produces exactly one single-cycle write strobe, carrying the data byte, for the register selected by the command. All three bytes are ACKed.
- R4: A combined read (address W, command, repeated START, address R) latches the command as the pointer and returns that register's contents MSB first.
- R5: A short read (address with R/W=1 directly after START) returns the register selected by the pointer that the most recent command phase latched.
- R6: A command byte above 07h is ACKed but leaves the pointer unchanged and blocks the write strobe.
- R7: A START or STOP seen during a transfer aborts it and restarts bit counting. The pointer is kept and no write occurs.
- R8: The target changes its SDA drive only while SCL is low, and it releases SDA after the ninth clock of each byte.
- R9: After reset SDA is released, no strobe is active and the pointer is 0.
- R10: In a write transaction, bytes after the data byte are neither ACKed nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_drive_low_o | output | 1 | Pulls SDA low when 1 |
| strap_i | input | 3 | Address strap pins |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_data_o | output | 8 | Data byte for the write strobe |
| ptr_o | output | 3 | Latched command pointer (read and write select) |
| rd_data_i | input | 8 | Contents of the register selected by ptr_o |

## Verification
The bench moves the straps after reset and addresses both the old and the new value. A design that kept sampling the pins would ACK the wrong address. Reserved commands are sent in both write and combined-read form and then followed by a short read. A design that latched them would move the pointer or strobe a write. A transfer is cut short by STOP partway through an address, and another by a repeated START partway through a data byte. A design that kept its bit count would misframe the next byte or commit a partial write. A trailing byte after the data byte checks that the target neither ACKs nor writes it.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } smbt_state_e;
endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/smbt_cond.sv
module smbt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank_target.sv
module smb_regbank_target #(
    parameter int             NREG        = 8,
    parameter int             STRAP_W     = 3,
    parameter logic [6-STRAP_W:0] ADDR_PREFIX = 4'b1000,
    parameter int             SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_drive_low_o,
    input  logic [STRAP_W-1:0]            strap_i,
    output logic                          wr_stb_o,
    output logic [smbt_pkg::BYTE_W-1:0]   wr_data_o,
    output logic [$clog2(NREG)-1:0]       ptr_o,
    input  logic [smbt_pkg::BYTE_W-1:0]   rd_data_i
);
    import smbt_pkg::*;

    localparam int AW    = $clog2(NREG);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    smbt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    smbt_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbt_state_e         state;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   sh;
    logic [BYTE_W-1:0]   rsh;
    logic [AW-1:0]       ptr;
    logic                cmd_ok;
    logic                rw;
    logic [STRAP_W-1:0]  strap_q;
    logic                cap_done;
    logic                wr_stb;
    logic [BYTE_W-1:0]   wr_data;
    logic                byte_state;
    logic                byte_full;
    logic [6:0]          own_addr;

    assign own_addr  = {ADDR_PREFIX, strap_q};
    assign byte_full = (cnt == CNT_W'(BYTE_W));

    always_comb begin
        byte_state = state inside {ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA};
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            rsh      <= '0;
            ptr      <= '0;
            cmd_ok   <= 1'b0;
            rw       <= 1'b0;
            strap_q  <= '0;
            cap_done <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!cap_done) begin
                strap_q  <= strap_i;
                cap_done <= 1'b1;
            end
            if (start_det) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                if (scl_rise && byte_state && !byte_full) begin
                    sh  <= {sh[BYTE_W-2:0], sda_s};
                    cnt <= cnt + 1'b1;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (byte_full) begin
                                cnt <= '0;
                                if (sh[BYTE_W-1:1] == own_addr) begin
                                    rw    <= sh[0];
                                    state <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        end
                        ST_ADDR_ACK: begin
                            cnt <= '0;
                            if (rw) begin
                                rsh   <= rd_data_i;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_CMD;
                            end
                        end
                        ST_CMD: begin
                            if (byte_full) begin
                                cnt <= '0;
                                if (sh < BYTE_W'(NREG)) begin
                                    cmd_ok <= 1'b1;
                                    ptr    <= sh[AW-1:0];
                                end else begin
                                    cmd_ok <= 1'b0;
                                end
                                state <= ST_CMD_ACK;
                            end
                        end
                        ST_CMD_ACK: begin
                            cnt   <= '0;
                            state <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            if (byte_full) begin
                                cnt <= '0;
                                if (cmd_ok) begin
                                    wr_stb  <= 1'b1;
                                    wr_data <= sh;
                                end
                                state <= ST_WDATA_ACK;
                            end
                        end
                        ST_WDATA_ACK: state <= ST_IGNORE;
                        ST_RDATA: begin
                            if (byte_full) begin
                                cnt   <= '0;
                                state <= ST_RDATA_ACK;
                            end else begin
                                rsh <= {rsh[BYTE_W-2:0], 1'b0};
                            end
                        end
                        ST_RDATA_ACK: state <= ST_IGNORE;
                        default: ;
                    endcase
                end
            end
        end
    end

    // output process
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_drive_low_o = 1'b1;
            ST_RDATA:                              sda_drive_low_o = ~rsh[BYTE_W-1];
            default:                               sda_drive_low_o = 1'b0;
        endcase
    end

    assign wr_stb_o  = wr_stb;
    assign wr_data_o = wr_data;
    assign ptr_o     = ptr;
endmodule

// File: rtl/smbt_checker.sv
module smbt_checker #(
    parameter int AW      = 3,
    parameter int STRAP_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  stop_det,
    input logic                  sda_drive_low_o,
    input logic                  wr_stb_o,
    input logic [AW-1:0]         ptr_o,
    input smbt_pkg::smbt_state_e state,
    input logic                  cap_done,
    input logic [STRAP_W-1:0]    strap_q
);
    import smbt_pkg::*;

    p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low_o != $past(sda_drive_low_o)) |-> !scl_s);

    p_release_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low_o);

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && $past(cap_done)) |-> $stable(strap_q));

    p_ptr_from_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_o != $past(ptr_o)) |-> ($past(state) == ST_CMD));
endmodule

bind smb_regbank_target smbt_checker #(.AW(AW), .STRAP_W(STRAP_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_s           (scl_s),
    .stop_det        (stop_det),
    .sda_drive_low_o (sda_drive_low_o),
    .wr_stb_o        (wr_stb_o),
    .ptr_o           (ptr_o),
    .state           (state),
    .cap_done        (cap_done),
    .strap_q         (strap_q)
);

// File: tb/sim_smb_regbank_target.sv
module sim_smb_regbank_target;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h45;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic drv, wr_stb;
    logic [7:0] wr_data, rd_data;
    logic [2:0] ptr;
    logic sda_bus;
    logic [7:0] bank [8];
    int n_stb;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~drv;
    assign rd_data = bank[ptr];

    smb_regbank_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low_o(drv), .strap_i(strap), .wr_stb_o(wr_stb),
        .wr_data_o(wr_data), .ptr_o(ptr), .rd_data_i(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) bank[i] <= 8'h10 + 8'(i);
            n_stb <= 0;
        end else if (wr_stb) begin
            bank[ptr] <= wr_data;
            n_stb     <= n_stb + 1;
        end
    end

    // op[17:16] 0=write 1=combined read 2=short read, cmd[15:8], data[7:0]
    localparam logic [17:0] VEC [10] = '{
        18'h003A5, 18'h0003C, 18'h00781, 18'h10300, 18'h20000,
        18'h10700, 18'h00500, 18'h10500, 18'h10100, 18'h20000
    };

    logic [7:0] mdl [8];
    logic [2:0] mptr;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b0; wclk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wclk(H);
        scl_m = 1'b1; wclk(H);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H/2);
        ack = (sda_bus == 1'b0);
        wclk(H/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit nack);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wclk(H);
            scl_m = 1'b1; wclk(H/2);
            b = {b[6:0], sda_bus};
            wclk(H/2);
            scl_m = 1'b0;
        end
        sda_m = nack; wclk(H);
        scl_m = 1'b1; wclk(H);
        scl_m = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                            output bit aa, output bit ac, output bit ad);
        bus_start();
        send_byte({a, 1'b0}, aa);
        send_byte(c, ac);
        send_byte(d, ad);
        wclk(H/2);
        chk(drv == 1'b0, "R8 release after ninth clock", drv, 0);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] c,
                           output logic [7:0] v, output bit aa);
        bit a1, a2;
        bus_start();
        send_byte({a, 1'b0}, a1);
        send_byte(c, a2);
        bus_start();
        send_byte({a, 1'b1}, aa);
        recv_byte(v, 1'b1);
        bus_stop();
    endtask

    task automatic do_recv(input logic [6:0] a, output logic [7:0] v, output bit aa);
        bus_start();
        send_byte({a, 1'b1}, aa);
        recv_byte(v, 1'b1);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit aa, ac, ad;
        logic [7:0] v;
        int s0;
        for (int i = 0; i < 8; i++) mdl[i] = 8'h10 + 8'(i);
        mptr = '0;
        wclk(10);
        rst_n = 1'b1;
        wclk(6);
        strap = 3'b010;
        wclk(4);
        // R9 reset state
        chk(drv == 1'b0, "R9 sda released", drv, 0);
        chk(wr_stb == 1'b0, "R9 no strobe", wr_stb, 0);
        chk(ptr == 3'd0, "R9 pointer zero", ptr, 0);

        // vector table
        for (int i = 0; i < 10; i++) begin
            logic [1:0] op;
            logic [7:0] c, d;
            op = VEC[i][17:16]; c = VEC[i][15:8]; d = VEC[i][7:0];
            case (op)
                2'd0: begin
                    s0 = n_stb;
                    do_write(OWN, c, d, aa, ac, ad);
                    mdl[c[2:0]] = d; mptr = c[2:0];
                    chk(aa && ac && ad, "R3 write acks", {aa, ac, ad}, 7);
                    chk(n_stb == s0 + 1, "R3 one strobe", n_stb - s0, 1);
                    chk(bank[c[2:0]] == d, "R3 data stored", bank[c[2:0]], d);
                end
                2'd1: begin
                    do_read(OWN, c, v, aa);
                    mptr = c[2:0];
                    chk(aa, "R4 read address ack", aa, 1);
                    chk(v == mdl[mptr], "R4 combined read data", v, mdl[mptr]);
                end
                default: begin
                    do_recv(OWN, v, aa);
                    chk(aa, "R5 short read ack", aa, 1);
                    chk(v == mdl[mptr], "R5 short read data", v, mdl[mptr]);
                end
            endcase
        end

        // R1 mismatch address ignored
        s0 = n_stb;
        do_write(7'h44, 8'h04, 8'hEE, aa, ac, ad);
        chk(!aa && !ac && !ad, "R1 mismatch nack", {aa, ac, ad}, 0);
        chk(n_stb == s0, "R1 no write on mismatch", n_stb - s0, 0);
        chk(ptr == mptr, "R1 pointer kept on mismatch", ptr, mptr);

        // R2 straps moved after reset: new value must not match
        do_recv(7'h42, v, aa);
        chk(!aa, "R2 late strap value not acked", aa, 0);
        do_recv(OWN, v, aa);
        chk(aa, "R2 captured strap still acked", aa, 1);

        // R6 reserved command in write and in combined read
        s0 = n_stb;
        do_write(OWN, 8'h08, 8'hFF, aa, ac, ad);
        chk(aa && ac && ad, "R6 reserved cmd acked", {aa, ac, ad}, 7);
        chk(n_stb == s0, "R6 no strobe on reserved", n_stb - s0, 0);
        chk(ptr == mptr, "R6 pointer unchanged", ptr, mptr);
        do_read(OWN, 8'h0B, v, aa);
        do_recv(OWN, v, aa);
        chk(v == mdl[mptr], "R6 short read after reserved", v, mdl[mptr]);

        // R7 STOP in the middle of an address byte
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        chk(drv == 1'b0, "R7 released after stop", drv, 0);
        s0 = n_stb;
        do_write(OWN, 8'h06, 8'h5A, aa, ac, ad);
        mdl[6] = 8'h5A; mptr = 3'd6;
        chk(aa && ac && ad && n_stb == s0 + 1, "R7 clean write after abort", n_stb - s0, 1);

        // R7 repeated START in the middle of a data byte
        s0 = n_stb;
        bus_start();
        send_byte({OWN, 1'b0}, aa);
        send_byte(8'h02, ac);
        mptr = 3'd2;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({OWN, 1'b1}, aa);
        recv_byte(v, 1'b1);
        bus_stop();
        chk(n_stb == s0, "R7 partial byte not written", n_stb - s0, 0);
        chk(v == mdl[2], "R7 pointer kept across restart", v, mdl[2]);

        // R10 bytes after the data byte
        s0 = n_stb;
        bus_start();
        send_byte({OWN, 1'b0}, aa);
        send_byte(8'h03, ac);
        send_byte(8'h77, ad);
        mdl[3] = 8'h77; mptr = 3'd3;
        send_byte(8'h99, aa);
        bus_stop();
        chk(!aa, "R10 extra byte not acked", aa, 0);
        chk(n_stb == s0 + 1, "R10 single write", n_stb - s0, 1);
        do_recv(OWN, v, aa);
        chk(v == 8'h77, "R10 register holds first data", v, 8'h77);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule